// File: doc/BRIEF.md
# Message-Signalled Interrupt Receiver Bank

This block collects message-signalled interrupts. A device signals an event by writing one 32-bit word to a fixed index address. The block turns that word into two fields: a select that names one of up to sixteen 32-bit pending registers, and a bit position inside that register. It then sets that bit. The bit stays set until software reads it.

Each pending register drives its own level interrupt output. The output is high whenever that register holds any set bit, so a cascading interrupt controller can see which group needs service. Software reads a pending register through a small register-read port. The value comes back one cycle after the request, and the read clears every bit it returns. No separate acknowledge write is needed.

Two static parameters change the behaviour. One picks the layout of the index word. The other enables a byte reversal of the written word before it is decoded, which models a controller that has an endianness fault. The spacing between the pending registers and the address of the index register are also parameters.

Top module: `msi_recv_bank`

## Requirements
- R1: With LAYOUT = IDX_LEGACY, an index write sets bit `data[4:0]` of pending register `data[8:5]`. Data bits 31:9 are ignored.
- R2: With LAYOUT = IDX_ALT, an index write sets bit `data[8:4]` of pending register `data[3:0]`. Data bits 31:9 are ignored.
- R3: With BYTE_SWAP = 1, the written word is byte-reversed before it is decoded. Byte 0 becomes byte 3 and byte 1 becomes byte 2. With BYTE_SWAP = 0, the word is decoded as written.
- R4: `irq_o[k]` is high exactly when pending register k holds at least one set bit. An index write is seen on `irq_o` in the cycle after the write.
- R5: A read request in cycle N at byte address k*STRIDE_BYTES, with k < NUM_REGS, returns register k's value in cycle N+1 with `rsp_valid_o` high. That read clears the bits it returned. `rsp_valid_o` is high only in the cycle after a read request.
- R6: When an index write to register k and a read of register k happen in the same cycle, the read returns the old value and the newly set bit stays pending for the next read.
- R7: A message write is ignored in two cases: its address is not INDEX_ADDR, or its decoded select is NUM_REGS or greater.
- R8: A read at an address that is not a multiple of STRIDE_BYTES, or that lies at or beyond NUM_REGS*STRIDE_BYTES, returns zero and clears nothing.
- R9: Reset clears all pending bits and holds every `irq_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_valid_i | input | 1 | Message write strobe |
| msg_addr_i | input | ADDR_W | Byte address of the message write |
| msg_data_i | input | 32 | Message write data (the index word) |
| rd_valid_i | input | 1 | Register read request |
| rd_addr_i | input | ADDR_W | Byte address of the register read |
| rsp_valid_o | output | 1 | Read data is valid; high the cycle after a request |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | NUM_REGS | Per-register level interrupt |

## Verification
The hardest case is an index write and a read of the same pending register in the same cycle. The old bits must be returned and cleared, and the new bit must survive for the next read. The bench first sets one bit in a register. In a later cycle it drives a read of that register together with an index write of a different bit of the same register, then reads again to see the surviving bit. A second instance uses the other index layout with byte reversal, so both decode variants are checked. Each instance also gets a long stretch of random traffic, compared against the reference model on every clock.

// File: rtl/msi_rx_pkg.sv
package msi_rx_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 4;
  localparam int BIT_W  = 5;
  localparam int MAX_REGS = 1 << SEL_W;

  typedef enum logic {
    IDX_LEGACY = 1'b0,  // bit in [4:0], select in [8:5]
    IDX_ALT    = 1'b1   // select in [3:0], bit in [8:4]
  } idx_layout_e;

  function automatic logic [WORD_W-1:0] byte_rev(input logic [WORD_W-1:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction
endpackage

// File: rtl/msi_index_decode.sv
module msi_index_decode
  import msi_rx_pkg::*;
#(
  parameter int          NUM_REGS   = 8,
  parameter idx_layout_e LAYOUT     = IDX_LEGACY,
  parameter bit          BYTE_SWAP  = 1'b0,
  parameter int          ADDR_W     = 12,
  parameter int          INDEX_ADDR = 'h140
) (
  input  logic                             msg_valid_i,
  input  logic [ADDR_W-1:0]                msg_addr_i,
  input  logic [WORD_W-1:0]                msg_data_i,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  set_vec_o
);
  logic [WORD_W-1:0] word;
  logic [SEL_W-1:0]  sel;
  logic [BIT_W-1:0]  pos;
  logic              hit;

  if (BYTE_SWAP) begin : g_swap
    assign word = byte_rev(msg_data_i);
  end else begin : g_plain
    assign word = msg_data_i;
  end

  if (LAYOUT == IDX_ALT) begin : g_alt
    assign sel = word[SEL_W-1:0];
    assign pos = word[SEL_W +: BIT_W];
  end else begin : g_legacy
    assign pos = word[BIT_W-1:0];
    assign sel = word[BIT_W +: SEL_W];
  end

  assign hit = msg_valid_i && (msg_addr_i == ADDR_W'(INDEX_ADDR));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_comb begin
      set_vec_o[k] = '0;
      if (hit && (sel == SEL_W'(k))) set_vec_o[k][pos] = 1'b1;
    end
  end
endmodule

// File: rtl/msi_read_decode.sv
module msi_read_decode #(
  parameter int NUM_REGS     = 8,
  parameter int ADDR_W       = 12,
  parameter int STRIDE_BYTES = 16
) (
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NUM_REGS-1:0] rd_hit_o
);
  localparam int STRIDE_LG = $clog2(STRIDE_BYTES);
  localparam int IDX_W     = ADDR_W - STRIDE_LG;

  logic              aligned;
  logic [IDX_W-1:0]  slot;

  assign aligned = (rd_addr_i[STRIDE_LG-1:0] == '0);
  assign slot    = rd_addr_i[ADDR_W-1:STRIDE_LG];

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
    assign rd_hit_o[k] = rd_valid_i && aligned && (slot == IDX_W'(k));
  end
endmodule

// File: rtl/msi_status_bank.sv
module msi_status_bank
  import msi_rx_pkg::*;
#(
  parameter int NUM_REGS = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [NUM_REGS-1:0][WORD_W-1:0] set_vec_i,
  input  logic [NUM_REGS-1:0]             rd_hit_i,
  output logic [NUM_REGS-1:0][WORD_W-1:0] pend_o,
  output logic [NUM_REGS-1:0]             irq_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[k] <= '0;
      else         pend_o[k] <= (rd_hit_i[k] ? '0 : pend_o[k]) | set_vec_i[k];
    end
    assign irq_o[k] = |pend_o[k];
  end
endmodule

// File: rtl/msi_recv_bank.sv
module msi_recv_bank
  import msi_rx_pkg::*;
#(
  parameter int          NUM_REGS     = 8,
  parameter idx_layout_e LAYOUT       = IDX_LEGACY,
  parameter bit          BYTE_SWAP    = 1'b0,
  parameter int          ADDR_W       = 12,
  parameter int          STRIDE_BYTES = 16,
  parameter int          INDEX_ADDR   = 'h140
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 msg_valid_i,
  input  logic [ADDR_W-1:0]    msg_addr_i,
  input  logic [31:0]          msg_data_i,
  input  logic                 rd_valid_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic                 rsp_valid_o,
  output logic [31:0]          rsp_rdata_o,
  output logic [NUM_REGS-1:0]  irq_o
);
  logic [NUM_REGS-1:0][WORD_W-1:0] set_vec;
  logic [NUM_REGS-1:0][WORD_W-1:0] pend;
  logic [NUM_REGS-1:0]             rd_hit;
  logic [WORD_W-1:0]               rd_mux;

  msi_index_decode #(
    .NUM_REGS(NUM_REGS), .LAYOUT(LAYOUT), .BYTE_SWAP(BYTE_SWAP),
    .ADDR_W(ADDR_W), .INDEX_ADDR(INDEX_ADDR)
  ) u_dec (
    .msg_valid_i(msg_valid_i), .msg_addr_i(msg_addr_i),
    .msg_data_i(msg_data_i), .set_vec_o(set_vec)
  );

  msi_read_decode #(
    .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W), .STRIDE_BYTES(STRIDE_BYTES)
  ) u_rdec (
    .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i), .rd_hit_o(rd_hit)
  );

  msi_status_bank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_vec_i(set_vec),
    .rd_hit_i(rd_hit), .pend_o(pend), .irq_o(irq_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (rd_hit[k]) rd_mux = rd_mux | pend[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= rd_valid_i;
      if (rd_valid_i) rsp_rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/msi_recv_bank_chk.sv
module msi_recv_bank_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        rd_valid_i,
  input logic                        rsp_valid_o,
  input logic [31:0]                 rsp_rdata_o,
  input logic [NUM_REGS-1:0]         irq_o,
  input logic [NUM_REGS-1:0][31:0]   set_vec,
  input logic [NUM_REGS-1:0]         rd_hit
);
  p_rsp_follows_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_i |=> rsp_valid_o);
  p_rsp_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_valid_i |=> !rsp_valid_o);
  p_single_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(set_vec) <= 1);
  p_hit_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_hit));
  p_miss_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_hit == '0) |=> rsp_rdata_o == '0);
  p_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_hit == '0 && set_vec == '0) |=> $stable(irq_o));

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_k
    p_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_hit[k] && set_vec[k] == '0) |=> !irq_o[k]);
    p_set_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|set_vec[k]) |=> irq_o[k]);
  end

  always @(posedge clk_i)
    if (!rst_ni) p_reset_r9: assert (irq_o == '0);
endmodule

bind msi_recv_bank msi_recv_bank_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_valid_i(rd_valid_i),
  .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .irq_o(irq_o),
  .set_vec(set_vec), .rd_hit(rd_hit)
);

// File: tb/test_msi_recv_bank.sv
module test_msi_recv_bank;
  import msi_rx_pkg::*;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  // instance A: legacy layout, no swap, 16-byte stride, index 0x140
  logic        a_mv = 0, a_rv = 0;
  logic [11:0] a_ma = 0, a_ra = 0;
  logic [31:0] a_md = 0;
  logic        a_rsp_v;
  logic [31:0] a_rsp_d;
  logic [N-1:0] a_irq;
  // instance B: alternate layout, swap, 4-byte stride, index 0x38
  logic        b_mv = 0, b_rv = 0;
  logic [11:0] b_ma = 0, b_ra = 0;
  logic [31:0] b_md = 0;
  logic        b_rsp_v;
  logic [31:0] b_rsp_d;
  logic [N-1:0] b_irq;

  msi_recv_bank #(.NUM_REGS(N), .LAYOUT(IDX_LEGACY), .BYTE_SWAP(1'b0),
    .ADDR_W(12), .STRIDE_BYTES(16), .INDEX_ADDR('h140)) i_msi_recv_bank (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(a_mv), .msg_addr_i(a_ma),
    .msg_data_i(a_md), .rd_valid_i(a_rv), .rd_addr_i(a_ra),
    .rsp_valid_o(a_rsp_v), .rsp_rdata_o(a_rsp_d), .irq_o(a_irq));

  msi_recv_bank #(.NUM_REGS(N), .LAYOUT(IDX_ALT), .BYTE_SWAP(1'b1),
    .ADDR_W(12), .STRIDE_BYTES(4), .INDEX_ADDR('h38)) i_msi_recv_bank_alt (
    .clk_i(clk), .rst_ni(rst_n), .msg_valid_i(b_mv), .msg_addr_i(b_ma),
    .msg_data_i(b_md), .rd_valid_i(b_rv), .rd_addr_i(b_ra),
    .rsp_valid_o(b_rsp_v), .rsp_rdata_o(b_rsp_d), .irq_o(b_irq));

  int tests = 0, fails = 0;
  string tag = "R9";
  logic [31:0] ma [N];
  logic [31:0] mb [N];

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] swap32(logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // reference model step; returns read response value
  function automatic logic [31:0] model(ref logic [31:0] m [N], input bit alt, input bit sw,
      input logic mv, input logic [11:0] madr, input logic [31:0] md, input int idx,
      input logic rv, input logic [11:0] radr, input int stride);
    logic [31:0] d, rsp;
    int sel, pos, r;
    rsp = 0;
    d = sw ? swap32(md) : md;
    if (alt) begin sel = int'(d & 15); pos = int'((d >> 4) & 31); end
    else     begin pos = int'(d & 31); sel = int'((d >> 5) & 15); end
    if (rv && (int'(radr) % stride == 0) && (int'(radr) / stride < N)) begin
      r = int'(radr) / stride;
      rsp = m[r];
      m[r] = 0;
    end
    if (mv && int'(madr) == idx && sel < N) m[sel][pos] = 1'b1;
    return rsp;
  endfunction

  function automatic logic [N-1:0] irqs(ref logic [31:0] m [N]);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = (m[k] != 0);
    return v;
  endfunction

  task automatic cycle();
    logic [31:0] ea, eb;
    logic era, erb;
    era = a_rv; erb = b_rv;
    ea = model(ma, 1'b0, 1'b0, a_mv, a_ma, a_md, 'h140, a_rv, a_ra, 16);
    eb = model(mb, 1'b1, 1'b1, b_mv, b_ma, b_md, 'h38,  b_rv, b_ra, 4);
    @(posedge clk); #1;
    check("A irq", 32'(a_irq), 32'(irqs(ma)));
    check("B irq", 32'(b_irq), 32'(irqs(mb)));
    check("A rsp_valid", 32'(a_rsp_v), 32'(era));
    check("B rsp_valid", 32'(b_rsp_v), 32'(erb));
    if (era) check("A rdata", a_rsp_d, ea);
    if (erb) check("B rdata", b_rsp_d, eb);
    a_mv = 0; a_rv = 0; b_mv = 0; b_rv = 0;
  endtask

  task automatic a_msg(logic [11:0] adr, logic [31:0] d);
    a_mv = 1; a_ma = adr; a_md = d;
  endtask
  task automatic a_rd(logic [11:0] adr);
    a_rv = 1; a_ra = adr;
  endtask

  bit done = 0;
  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) begin ma[k] = 0; mb[k] = 0; end
    tag = "R9";
    #35;
    check("A irq in reset", 32'(a_irq), 0);
    check("B irq in reset", 32'(b_irq), 0);
    check("A rsp_valid in reset", 32'(a_rsp_v), 0);
    rst_n = 1'b1;
    cycle();

    tag = "R1";   // reg 2 bit 7; upper junk ignored
    a_msg('h140, 32'hFFFF_FE00 | (2 << 5) | 7); cycle();
    a_msg('h140, (2 << 5) | 20); cycle();
    tag = "R4"; cycle();
    tag = "R5"; a_rd('h20); cycle();
    a_rd('h20); cycle();

    tag = "R7";   // select 9 out of bank, wrong address
    a_msg('h140, (9 << 5) | 3); cycle();
    a_msg('h144, (1 << 5) | 3); cycle();
    a_rd('h10); cycle();

    tag = "R6";   // pre-set bit 1 of reg 3, then read+write same cycle
    a_msg('h140, (3 << 5) | 1); cycle();
    a_msg('h140, (3 << 5) | 5); a_rd('h30); cycle();
    a_rd('h30); cycle();

    tag = "R8";   // misaligned and beyond-bank reads leave pending intact
    a_msg('h140, (4 << 5) | 9); cycle();
    a_rd('h44); cycle();
    a_rd('h80); cycle();
    a_rd('h140); cycle();
    a_rd('h40); cycle();

    tag = "R2";   // select 5 bit 17 in alternate layout, swapped on the wire
    tag = "R3";
    b_mv = 1; b_ma = 'h38; b_md = swap32((17 << 4) | 5); cycle();
    b_rv = 1; b_ra = 5 * 4; cycle();
    b_mv = 1; b_ma = 'h38; b_md = (31 << 4) | 7; cycle(); // unswapped word decodes elsewhere
    b_rv = 1; b_ra = 7 * 4; cycle();
    for (int k = 0; k < N; k++) begin b_rv = 1; b_ra = 12'(k * 4); cycle(); end

    tag = "R2";   // random traffic on both instances
    for (int i = 0; i < 3000; i++) begin
      a_mv = 1'($urandom); a_md = $urandom & 32'h1FF;
      a_ma = ($urandom % 8 == 0) ? 12'h13C : 12'h140;
      a_rv = 1'($urandom % 3 == 0); a_ra = 12'($urandom % 160);
      b_mv = 1'($urandom); b_md = swap32($urandom & 32'h1FF);
      b_ma = ($urandom % 8 == 0) ? 12'h3C : 12'h38;
      b_rv = 1'($urandom % 3 == 0); b_ra = 12'($urandom % 40);
      cycle();
    end
    tag = "R1"; cycle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule